// File: doc/BRIEF.md
# Arbitrated Serial EEPROM Bit-Bang Port

This block gives software direct pin-level control of a one-bit serial EEPROM that hangs off a memory port shared with another user. Software writes a request bit into an eight-bit control register. The block then waits until the other user of the shared port is idle and takes ownership. From that point the chip-select, clock and data-out bits of the register drive the EEPROM pins, and the EEPROM's data output can be read back through the register.

One status bit does two jobs. The first time ownership is obtained, the ready bit rises together with ownership and means "access granted". After that, every register write made while the port is owned clears ready, and ready rises again a fixed time later, about 800 ns. Software can therefore pace its clock edges by polling the same bit. The EEPROM command sequence itself is generated entirely by software.

Clearing the request bit gives the shared port back. The EEPROM pins are held inactive whenever the port is not owned.

Top module: `eeprom_bitbang_port`

## Requirements
- R1: After synchronous reset, with `ee_di` and `port_busy` held low, `rd_data` reads 0x00, `port_own` is low, and `ee_cs`, `ee_sk` and `ee_do` are low.
- R2: A write with bit 5 (request) set asks for the shared port. `port_busy` is registered once, so ownership (`port_own`) rises on the second rising edge after `port_busy` is seen low. While the registered busy is high, no grant is given.
- R3: On the edge at which ownership is first granted, the ready bit (bit 4) rises in the same cycle, with no delay count.
- R4: A write while the port is owned clears ready on that write edge. Ready rises again exactly DELAY_CYC rising edges later. DELAY_CYC is the ceiling of DELAY_PS divided by CLK_PERIOD_PS, which gives 40 for 800 ns at 50 MHz.
- R5: If an owned write arrives on the same edge at which the delay would expire, the write wins. Ready stays low and the full DELAY_CYC count restarts from that write.
- R6: While the port is not owned, `ee_cs`, `ee_sk` and `ee_do` are low, whatever is held in register bits 3, 2 and 1.
- R7: While the port is owned, `ee_cs`, `ee_sk` and `ee_do` equal bits 3, 2 and 1 of the most recent write, starting from the edge of that write.
- R8: `ee_di` passes through a two-flop synchronizer. A change appears in `rd_data` bit 0 on the second rising edge after it is presented.
- R9: A write with bit 5 clear, made while the port is owned, clears ready on that edge. `port_own` falls one edge later, and the EEPROM pins then go low.
- R10: `rd_data` is laid out as follows: bit 7 ownership, bit 6 the registered `port_busy`, bit 5 request, bit 4 ready, bits 3 to 1 chip-select, clock and data-out, bit 0 synchronized EEPROM data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write value |
| rd_data | output | 8 | Control/status register read value |
| port_busy | input | 1 | Other user of the shared memory port is active |
| port_own | output | 1 | This block owns the shared memory port |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_do | output | 1 | Data to the EEPROM |
| ee_di | input | 1 | Data from the EEPROM |

## Verification
Two events can land on the same clock edge: the delay timer expiring and a new owned register write. The bench times a second write so that it is captured exactly DELAY_CYC edges after the first one, which is the edge at which ready would otherwise rise. It then checks two things: that ready is still low on that edge, and that ready rises only a full DELAY_CYC edges after the second write. The scoreboard compares `rd_data`, ownership and the pins at every scheduled cycle of this window, and a checker assertion measures the write-to-ready distance on every rise.

// File: rtl/eeprom_port_pkg.sv
// Shared constants for the EEPROM bit-bang port: control register bit positions.
// Assumes an eight-bit control register; software depends on these positions.
package eeprom_port_pkg;
    localparam int unsigned CTRL_W  = 8;
    localparam int unsigned BIT_OWN = 7;
    localparam int unsigned BIT_BSY = 6;
    localparam int unsigned BIT_REQ = 5;
    localparam int unsigned BIT_RDY = 4;
    localparam int unsigned BIT_CS  = 3;
    localparam int unsigned BIT_SK  = 2;
    localparam int unsigned BIT_DO  = 1;
    localparam int unsigned BIT_DI  = 0;
endpackage

// File: rtl/eeprom_sync.sv
// Multi-flop synchronizer for the asynchronous EEPROM data-out pin.
// Assumes STAGES >= 2; the output is the last flop of the chain.
module eeprom_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    // Shift the pin value through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/eeprom_arb.sv
// Arbitration for the shared memory port.
// Samples the other user's busy flag once per cycle and takes ownership when a
// request is pending and the sampled busy flag is low. Ownership is dropped on
// the edge after the request is withdrawn.
module eeprom_arb (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic busy_i,
    output logic busy_s_o,
    output logic own_o,
    output logic grant_o
);
    logic busy_q;
    logic own_q;

    // Register the busy flag from the other port user.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= 1'b0;
        else        busy_q <= busy_i;
    end

    assign grant_o = req_i & ~own_q & ~busy_q;

    // Hold ownership while requested; take it on a grant.
    always_ff @(posedge clk) begin
        if (!rst_n)       own_q <= 1'b0;
        else if (!req_i)  own_q <= 1'b0;
        else if (grant_o) own_q <= 1'b1;
    end

    assign busy_s_o = busy_q;
    assign own_o    = own_q;
endmodule

// File: rtl/eeprom_delay_timer.sv
// Ready flag generator.
// Sets ready at once on a first grant. While the port is owned, every register
// write clears ready and reloads a down-counter; ready returns when the counter
// runs out. A write that keeps the request reloads the full count; a releasing
// write only clears ready.
module eeprom_delay_timer #(
    parameter int unsigned DELAY_CYC = 40,
    parameter int unsigned CNT_W     = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic own_i,
    input  logic grant_i,
    input  logic wr_i,
    input  logic keep_i,
    output logic ready_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             ready_q;

    // Priority: no ownership, grant, owned write, count down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            ready_q <= 1'b0;
        end else if (!own_i && !grant_i) begin
            cnt_q   <= '0;
            ready_q <= 1'b0;
        end else if (grant_i) begin
            cnt_q   <= '0;
            ready_q <= 1'b1;
        end else if (wr_i) begin
            cnt_q   <= keep_i ? CNT_W'(DELAY_CYC) : '0;
            ready_q <= 1'b0;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CNT_W'(1)) ready_q <= 1'b1;
        end
    end

    assign ready_o = ready_q;
endmodule

// File: rtl/eeprom_bitbang_port.sv
// Register-controlled EEPROM bit-bang port on an arbitrated shared memory port.
// Holds the request and pin-control bits, gates the pins with ownership, and
// assembles the read-back value. Assumes DELAY_PS and CLK_PERIOD_PS give a
// nonzero delay count and that ee_di may be asynchronous.
module eeprom_bitbang_port
    import eeprom_port_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_PS = 20000,
    parameter int unsigned DELAY_PS      = 800000,
    parameter int unsigned SYNC_STAGES   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] rd_data,
    input  logic              port_busy,
    output logic              port_own,
    output logic              ee_cs,
    output logic              ee_sk,
    output logic              ee_do,
    input  logic              ee_di
);
    localparam int unsigned DELAY_CYC = (DELAY_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
    localparam int unsigned CNT_W     = $clog2(DELAY_CYC + 1);

    logic req_q, cs_q, sk_q, do_q;
    logic own, grant, busy_s, ready, di_s;
    logic unused_wr_bits;

    assign unused_wr_bits = ^{wr_data[BIT_OWN], wr_data[BIT_BSY], wr_data[BIT_RDY], wr_data[BIT_DI]};

    // Capture the software-writable register bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
            cs_q  <= 1'b0;
            sk_q  <= 1'b0;
            do_q  <= 1'b0;
        end else if (wr_en) begin
            req_q <= wr_data[BIT_REQ];
            cs_q  <= wr_data[BIT_CS];
            sk_q  <= wr_data[BIT_SK];
            do_q  <= wr_data[BIT_DO];
        end
    end

    eeprom_arb u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (req_q),
        .busy_i   (port_busy),
        .busy_s_o (busy_s),
        .own_o    (own),
        .grant_o  (grant)
    );

    eeprom_delay_timer #(
        .DELAY_CYC (DELAY_CYC),
        .CNT_W     (CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .own_i   (own),
        .grant_i (grant),
        .wr_i    (wr_en & own),
        .keep_i  (wr_data[BIT_REQ]),
        .ready_o (ready)
    );

    eeprom_sync #(
        .STAGES (SYNC_STAGES)
    ) u_di_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (ee_di),
        .q_o   (di_s)
    );

    // Pins are driven only while the shared port is owned.
    assign ee_cs    = own & cs_q;
    assign ee_sk    = own & sk_q;
    assign ee_do    = own & do_q;
    assign port_own = own;

    // Assemble the read-back value.
    always_comb begin
        rd_data          = '0;
        rd_data[BIT_OWN] = own;
        rd_data[BIT_BSY] = busy_s;
        rd_data[BIT_REQ] = req_q;
        rd_data[BIT_RDY] = ready;
        rd_data[BIT_CS]  = cs_q;
        rd_data[BIT_SK]  = sk_q;
        rd_data[BIT_DO]  = do_q;
        rd_data[BIT_DI]  = di_s;
    end
endmodule

// File: rtl/eeprom_port_checker.sv
// Property checker for eeprom_bitbang_port, attached by bind.
// Watches only ports; keeps its own counter of cycles since the last owned write.
module eeprom_port_checker #(
    parameter int unsigned DELAY_CYC = 40
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       port_busy,
    input logic       port_own,
    input logic [7:0] rd_data,
    input logic       ee_cs,
    input logic       ee_sk,
    input logic       ee_do
);
    logic [15:0] since_wr;

    // Count edges since the last write made while owning the port.
    always_ff @(posedge clk) begin
        if (!rst_n)                  since_wr <= '0;
        else if (port_own && wr_en)  since_wr <= '0;
        else if (since_wr != 16'hFFFF) since_wr <= since_wr + 1'b1;
    end

    AST_GRANT_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(port_own) |-> !$past(port_busy, 2)); // R2
    AST_FIRST_GRANT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(port_own) |-> rd_data[4]); // R3
    AST_DELAY_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rd_data[4]) && $past(port_own)) |-> (since_wr == 16'(DELAY_CYC))); // R4
    AST_WRITE_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (port_own && wr_en) |=> !rd_data[4]); // R5
    AST_PINS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !port_own |-> (!ee_cs && !ee_sk && !ee_do)); // R6
    AST_RELEASE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (port_own && !rd_data[5]) |=> !port_own); // R9
    AST_READY_NEEDS_OWN: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[4] |-> port_own); // R9
endmodule

bind eeprom_bitbang_port eeprom_port_checker #(
    .DELAY_CYC (DELAY_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .port_busy (port_busy),
    .port_own  (port_own),
    .rd_data   (rd_data),
    .ee_cs     (ee_cs),
    .ee_sk     (ee_sk),
    .ee_do     (ee_do)
);

// File: tb/eeprom_bitbang_port_bench.sv
// Scoreboard bench: the stimulus pushes expected values tagged with an absolute
// cycle number; a monitor compares them at the falling edge of that cycle.
module eeprom_bitbang_port_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       port_busy = 1'b0;
    logic       port_own;
    logic       ee_cs, ee_sk, ee_do;
    logic       ee_di = 1'b0;

    typedef struct {
        int         cyc;
        logic [7:0] rd;
        logic [2:0] pins;
        logic       own;
        string      tag;
    } exp_t;

    exp_t sbq[$];
    exp_t item;
    int   cyc = 0;
    int   n_vec = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    eeprom_bitbang_port u_eeprom_bitbang_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .port_busy (port_busy),
        .port_own  (port_own),
        .ee_cs     (ee_cs),
        .ee_sk     (ee_sk),
        .ee_do     (ee_do),
        .ee_di     (ee_di)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic push(input int c, input logic [7:0] rd, input logic [2:0] pins,
                        input logic own, input string tag);
        exp_t e;
        e.cyc = c; e.rd = rd; e.pins = pins; e.own = own; e.tag = tag;
        sbq.push_back(e);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Drive one write; it is captured on the next rising edge.
    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    // Monitor: pop and compare the items due in this cycle.
    always @(negedge clk) begin
        while (sbq.size() > 0 && sbq[0].cyc <= cyc) begin
            item = sbq.pop_front();
            n_vec++;
            if (item.cyc < cyc) begin
                n_bad++;
                $display("FAIL %s: expectation for cycle %0d missed (now %0d)", item.tag, item.cyc, cyc);
            end else if (rd_data !== item.rd || {ee_cs, ee_sk, ee_do} !== item.pins ||
                         port_own !== item.own) begin
                n_bad++;
                $display("FAIL %s @%0d: rd=%h pins=%b own=%b, expected rd=%h pins=%b own=%b",
                         item.tag, cyc, rd_data, {ee_cs, ee_sk, ee_do}, port_own,
                         item.rd, item.pins, item.own);
            end
        end
    end

    // Watchdog: a hung run counts as a miscompare.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        push(cyc + 1, 8'h00, 3'b000, 1'b0, "R1 reset state");
        push(cyc + 2, 8'h00, 3'b000, 1'b0, "R1 reset state held");
        idle(2);

        // R10: registered busy appears in bit 6
        port_busy = 1'b1;
        push(cyc + 1, 8'h40, 3'b000, 1'b0, "R10 busy bit");
        idle(1);

        // R2 and R6: request with pin bits while busy; no grant, pins idle
        push(cyc + 1, 8'h6E, 3'b000, 1'b0, "R6 pins idle while pending");
        push(cyc + 3, 8'h6E, 3'b000, 1'b0, "R2 no grant while busy");
        wr(8'h2E);
        idle(2);

        // R2 and R3: busy falls, grant two edges later with ready at once
        port_busy = 1'b0;
        push(cyc + 1, 8'h2E, 3'b000, 1'b0, "R2 grant not yet");
        push(cyc + 2, 8'hBE, 3'b111, 1'b1, "R3 grant with ready");
        idle(2);

        // R7 and R4: owned write drops ready for DELAY_CYC edges
        push(cyc + 1,  8'hA8, 3'b100, 1'b1, "R7 pins follow write");
        push(cyc + 40, 8'hA8, 3'b100, 1'b1, "R4 ready still low");
        push(cyc + 41, 8'hB8, 3'b100, 1'b1, "R4 ready back");
        wr(8'h28);
        idle(41);

        // R5: second write lands on the expiry edge of the first
        push(cyc + 1,       8'hAC, 3'b110, 1'b1, "R5 first write");
        push(cyc + 40,      8'hAC, 3'b110, 1'b1, "R5 before expiry");
        push(cyc + 41,      8'hAA, 3'b101, 1'b1, "R5 write wins expiry");
        push(cyc + 41 + 39, 8'hAA, 3'b101, 1'b1, "R5 restarted count");
        push(cyc + 41 + 40, 8'hBA, 3'b101, 1'b1, "R5 ready after restart");
        wr(8'h2C);
        idle(39);
        wr(8'h2A);
        idle(40);

        // R8: data-in through two flops
        push(cyc + 1, 8'hBA, 3'b101, 1'b1, "R8 rise not yet");
        push(cyc + 2, 8'hBB, 3'b101, 1'b1, "R8 rise visible");
        ee_di = 1'b1;
        idle(2);
        push(cyc + 1, 8'hBB, 3'b101, 1'b1, "R8 fall not yet");
        push(cyc + 2, 8'hBA, 3'b101, 1'b1, "R8 fall visible");
        ee_di = 1'b0;
        idle(2);

        // R9: release drops ready, ownership one edge later
        push(cyc + 1, 8'h8E, 3'b111, 1'b1, "R9 release drops ready");
        push(cyc + 2, 8'h0E, 3'b000, 1'b0, "R9 ownership released");
        push(cyc + 3, 8'h0E, 3'b000, 1'b0, "R6 pins idle after release");
        wr(8'h0E);
        idle(3);

        // R10: busy seen while idle
        port_busy = 1'b1;
        push(cyc + 1, 8'h4E, 3'b000, 1'b0, "R10 busy bit idle");
        idle(3);

        done = 1'b1;
        report();
    end
endmodule